// File: doc/BRIEF.md
# Cross-Clock Mailbox Register Pair

This block gives two independently clocked ports a way to pass single words to each other without going through a queue. It holds two word-wide mailboxes. The first is loaded from port A and fetched at port B. The second is loaded from port B and fetched at port A. Each port has a mailbox select input. When select is high, a qualified access on that port goes to the mailbox instead of the neighbouring FIFO. The same select input also picks what the port's read bus shows: the mailbox word, or the FIFO output word that is supplied from outside.

Each mailbox has an active-low "unread mail" flag. The flag appears in both domains.
- In the writer's domain it drops at the edge that stores the word. While it is low, further stores to that mailbox are refused.
- The reader's copy follows through a two-flop synchronizer.
- A qualified read with select high, made while mail is pending, raises the reader's copy at once. It sends a toggle back, and that toggle raises the writer's copy two writer edges later.

An access is qualified when chip select is low and enable is high at a rising edge of the port's clock. The write/read input then picks the direction.

Top module: `xclk_mailbox`

## Requirements
- R1: After reset all four flag outputs (`a_mb1_n`, `b_mb1_n`, `a_mb2_n`, `b_mb2_n`) are high.
- R2: A port A access with `a_cs_n`=0, `a_en`=1, `a_wr`=1, `a_mbsel`=1 at a rising `clk_a` edge, while `a_mb1_n` is high, stores `a_wdata` into mailbox 1. It drives `a_mb1_n` low right after that edge.
- R3: While `a_mb1_n` is low, mailbox 1 writes are refused and the stored word does not change.
- R4: After a mailbox 1 write, `b_mb1_n` is still high after the first rising `clk_b` edge and is low after the second.
- R5: A port B access with `b_cs_n`=0, `b_en`=1, `b_wr`=0, `b_mbsel`=1 while `b_mb1_n` is low sets `b_mb1_n` high at that edge. `a_mb1_n` then stays low after the next rising `clk_a` edge and is high after the second.
- R6: `b_rdata` shows mailbox 1 when `b_mbsel` is 1 and `b_fifo_q` when it is 0. A port B read with `b_mbsel`=0 leaves both mailbox 1 flags unchanged.
- R7: An access with chip select high, enable low, select low or the wrong direction changes neither the mailbox word nor its flags.
- R8: Mailbox 2 mirrors R2 to R6 with the ports swapped. Port B writes it and drives `b_mb2_n`. Port A reads it, sees `a_mb2_n`, and `a_rdata` picks between mailbox 2 and `a_fifo_q` on `a_mbsel`.
- R9: A mailbox read while no mail is pending changes nothing: both flags stay high and the next write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| clk_a | input | 1 | Port A clock |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_en | input | 1 | Port A enable |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_mbsel | input | 1 | Port A mailbox select |
| a_wdata | input | W | Port A write word |
| a_fifo_q | input | W | FIFO output word shown at port A when select is low |
| a_rdata | output | W | Port A read word |
| a_mb1_n | output | 1 | Mailbox 1 flag, writer view (A domain) |
| a_mb2_n | output | 1 | Mailbox 2 flag, reader view (A domain) |
| clk_b | input | 1 | Port B clock |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_en | input | 1 | Port B enable |
| b_wr | input | 1 | Port B direction: 1 write, 0 read |
| b_mbsel | input | 1 | Port B mailbox select |
| b_wdata | input | W | Port B write word |
| b_fifo_q | input | W | FIFO output word shown at port B when select is low |
| b_rdata | output | W | Port B read word |
| b_mb1_n | output | 1 | Mailbox 1 flag, reader view (B domain) |
| b_mb2_n | output | 1 | Mailbox 2 flag, writer view (B domain) |

## Verification
The bench builds the block with `W` = 8. This keeps every stored word distinct and easy to trace, while the control path is the same as at full width. Port A runs at 100 MHz. Port B runs at 62.5 MHz, with its edges offset so that the edges of the two clocks never coincide. This makes it possible to count the edges of each flag crossing one by one. All sixteen combinations of the four port A controls are swept against mailbox 1, and so are the eight port B read combinations. This shows that exactly one combination stores a word and exactly one clears the flag.

// File: rtl/xclk_mailbox.sv
module xclk_mailbox #(
  parameter int W = 36
) (
  input  logic         rst_n,
  input  logic         clk_a,
  input  logic         a_cs_n,
  input  logic         a_en,
  input  logic         a_wr,
  input  logic         a_mbsel,
  input  logic [W-1:0] a_wdata,
  input  logic [W-1:0] a_fifo_q,
  output logic [W-1:0] a_rdata,
  output logic         a_mb1_n,
  output logic         a_mb2_n,
  input  logic         clk_b,
  input  logic         b_cs_n,
  input  logic         b_en,
  input  logic         b_wr,
  input  logic         b_mbsel,
  input  logic [W-1:0] b_wdata,
  input  logic [W-1:0] b_fifo_q,
  output logic [W-1:0] b_rdata,
  output logic         b_mb1_n,
  output logic         b_mb2_n
);

  logic [W-1:0] mail1, mail2;
  logic m1_wt, m1_rt, m1_ack1, m1_ack2, m1_wt1, m1_wt2;
  logic m2_wt, m2_rt, m2_ack1, m2_ack2, m2_wt1, m2_wt2;
  logic a_go, b_go, m1_put, m1_take, m2_put, m2_take;

  assign a_go = !a_cs_n && a_en && a_mbsel;
  assign b_go = !b_cs_n && b_en && b_mbsel;

  // toggle handshake: writer flips *_wt, reader flips *_rt; equal means empty
  assign a_mb1_n = (m1_wt == m1_ack2);
  assign b_mb1_n = (m1_wt2 == m1_rt);
  assign b_mb2_n = (m2_wt == m2_ack2);
  assign a_mb2_n = (m2_wt2 == m2_rt);

  assign m1_put  = a_go &&  a_wr && a_mb1_n;
  assign m1_take = b_go && !b_wr && !b_mb1_n;
  assign m2_put  = b_go &&  b_wr && b_mb2_n;
  assign m2_take = a_go && !a_wr && !a_mb2_n;

  assign a_rdata = a_mbsel ? mail2 : a_fifo_q;
  assign b_rdata = b_mbsel ? mail1 : b_fifo_q;

  always_ff @(posedge clk_a or negedge rst_n) begin
    if (!rst_n) begin
      mail1   <= '0;
      m1_wt   <= 1'b0;
      m1_ack1 <= 1'b0;
      m1_ack2 <= 1'b0;
      m2_rt   <= 1'b0;
      m2_wt1  <= 1'b0;
      m2_wt2  <= 1'b0;
    end else begin
      if (m1_put) begin
        mail1 <= a_wdata;
        m1_wt <= !m1_wt;
      end
      if (m2_take) m2_rt <= !m2_rt;
      m1_ack1 <= m1_rt;
      m1_ack2 <= m1_ack1;
      m2_wt1  <= m2_wt;
      m2_wt2  <= m2_wt1;
    end
  end

  always_ff @(posedge clk_b or negedge rst_n) begin
    if (!rst_n) begin
      mail2   <= '0;
      m2_wt   <= 1'b0;
      m2_ack1 <= 1'b0;
      m2_ack2 <= 1'b0;
      m1_rt   <= 1'b0;
      m1_wt1  <= 1'b0;
      m1_wt2  <= 1'b0;
    end else begin
      if (m2_put) begin
        mail2 <= b_wdata;
        m2_wt <= !m2_wt;
      end
      if (m1_take) m1_rt <= !m1_rt;
      m2_ack1 <= m2_rt;
      m2_ack2 <= m2_ack1;
      m1_wt1  <= m1_wt;
      m1_wt2  <= m1_wt1;
    end
  end

endmodule

// File: rtl/xclk_mailbox_chk.sv
module xclk_mailbox_chk #(
  parameter int W = 36
) (
  input logic         rst_n,
  input logic         clk_a,
  input logic         a_cs_n,
  input logic         a_en,
  input logic         a_wr,
  input logic         a_mbsel,
  input logic         a_mb1_n,
  input logic         a_mb2_n,
  input logic         clk_b,
  input logic         b_cs_n,
  input logic         b_en,
  input logic         b_wr,
  input logic         b_mbsel,
  input logic         b_mb1_n,
  input logic         b_mb2_n,
  input logic [W-1:0] mail1,
  input logic [W-1:0] mail2
);

  a_r2_store_drops_flag: assert property (@(posedge clk_a) disable iff (!rst_n)
    (!a_cs_n && a_en && a_wr && a_mbsel && a_mb1_n) |=> !a_mb1_n);

  a_r3_word_held: assert property (@(posedge clk_a) disable iff (!rst_n)
    !a_mb1_n |=> $stable(mail1));

  a_r5_read_raises: assert property (@(posedge clk_b) disable iff (!rst_n)
    (!b_cs_n && b_en && !b_wr && b_mbsel && !b_mb1_n) |=> b_mb1_n);

  a_r6_flag_kept: assert property (@(posedge clk_b) disable iff (!rst_n)
    (!b_mb1_n && !(!b_cs_n && b_en && !b_wr && b_mbsel)) |=> !b_mb1_n);

  a_r8_store_drops_flag2: assert property (@(posedge clk_b) disable iff (!rst_n)
    (!b_cs_n && b_en && b_wr && b_mbsel && b_mb2_n) |=> !b_mb2_n);

  a_r8_word_held2: assert property (@(posedge clk_b) disable iff (!rst_n)
    !b_mb2_n |=> $stable(mail2));

  a_r8_read_raises2: assert property (@(posedge clk_a) disable iff (!rst_n)
    (!a_cs_n && a_en && !a_wr && a_mbsel && !a_mb2_n) |=> a_mb2_n);

endmodule

bind xclk_mailbox xclk_mailbox_chk #(.W(W)) u_chk (
  .rst_n(rst_n), .clk_a(clk_a), .a_cs_n(a_cs_n), .a_en(a_en), .a_wr(a_wr),
  .a_mbsel(a_mbsel), .a_mb1_n(a_mb1_n), .a_mb2_n(a_mb2_n),
  .clk_b(clk_b), .b_cs_n(b_cs_n), .b_en(b_en), .b_wr(b_wr),
  .b_mbsel(b_mbsel), .b_mb1_n(b_mb1_n), .b_mb2_n(b_mb2_n),
  .mail1(mail1), .mail2(mail2)
);

// File: tb/xclk_mailbox_tb.sv
module xclk_mailbox_tb;
  localparam int W = 8;

  logic rst_n = 1'b0;
  logic clk_a = 1'b0, clk_b = 1'b0;
  logic a_cs_n = 1'b1, a_en = 1'b0, a_wr = 1'b0, a_mbsel = 1'b0;
  logic b_cs_n = 1'b1, b_en = 1'b0, b_wr = 1'b0, b_mbsel = 1'b0;
  logic [W-1:0] a_wdata = '0, b_wdata = '0;
  logic [W-1:0] a_fifo_q = 8'hA5, b_fifo_q = 8'h3C;
  logic [W-1:0] a_rdata, b_rdata;
  logic a_mb1_n, a_mb2_n, b_mb1_n, b_mb2_n;
  int checks = 0, errors = 0;

  xclk_mailbox #(.W(W)) u_dut (
    .rst_n(rst_n), .clk_a(clk_a), .a_cs_n(a_cs_n), .a_en(a_en), .a_wr(a_wr),
    .a_mbsel(a_mbsel), .a_wdata(a_wdata), .a_fifo_q(a_fifo_q), .a_rdata(a_rdata),
    .a_mb1_n(a_mb1_n), .a_mb2_n(a_mb2_n),
    .clk_b(clk_b), .b_cs_n(b_cs_n), .b_en(b_en), .b_wr(b_wr),
    .b_mbsel(b_mbsel), .b_wdata(b_wdata), .b_fifo_q(b_fifo_q), .b_rdata(b_rdata),
    .b_mb1_n(b_mb1_n), .b_mb2_n(b_mb2_n)
  );

  always #5 clk_a = ~clk_a;
  initial begin
    #2;
    forever begin
      clk_b = 1'b1; #8;
      clk_b = 1'b0; #8;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkb(input string req, input logic act, input logic exp);
    chk(act === exp, req, {7'd0, act}, {7'd0, exp});
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic apply_a(input logic cs_n, input logic en, input logic wr, input logic sel, input logic [W-1:0] d);
    @(negedge clk_a);
    a_cs_n = cs_n; a_en = en; a_wr = wr; a_mbsel = sel; a_wdata = d;
    @(posedge clk_a); #1;
    a_cs_n = 1'b1; a_en = 1'b0;
  endtask

  task automatic apply_b(input logic cs_n, input logic en, input logic wr, input logic sel, input logic [W-1:0] d);
    @(negedge clk_b);
    b_cs_n = cs_n; b_en = en; b_wr = wr; b_mbsel = sel; b_wdata = d;
    @(posedge clk_b); #1;
    b_cs_n = 1'b1; b_en = 1'b0;
  endtask

  task automatic wait_a(input int n);
    repeat (n) @(posedge clk_a);
    #1;
  endtask

  task automatic wait_b(input int n);
    repeat (n) @(posedge clk_b);
    #1;
  endtask

  initial begin
    #1_000_000;
    chk(1'b0, "watchdog", '0, '1);
    finish_run();
  end

  initial begin
    logic [W-1:0] last;
    logic cleared;
    repeat (4) @(posedge clk_a);
    #1 rst_n = 1'b1;
    wait_a(1);

    // R1 reset state
    chkb("R1 a_mb1_n", a_mb1_n, 1'b1);
    chkb("R1 b_mb1_n", b_mb1_n, 1'b1);
    chkb("R1 a_mb2_n", a_mb2_n, 1'b1);
    chkb("R1 b_mb2_n", b_mb2_n, 1'b1);

    // R9 read of an empty mailbox
    apply_b(1'b0, 1'b1, 1'b0, 1'b1, '0);
    chkb("R9 b_mb1_n after empty read", b_mb1_n, 1'b1);
    wait_a(3);
    chkb("R9 a_mb1_n after empty read", a_mb1_n, 1'b1);

    // R2, R4 store and reader timing
    apply_a(1'b0, 1'b1, 1'b1, 1'b1, 8'h11);
    chkb("R2 a_mb1_n low after store", a_mb1_n, 1'b0);
    wait_b(1);
    chkb("R4 b_mb1_n after first edge", b_mb1_n, 1'b1);
    wait_b(1);
    chkb("R4 b_mb1_n after second edge", b_mb1_n, 1'b0);
    b_mbsel = 1'b1; #1;
    chk(b_rdata === 8'h11, "R2 stored word", b_rdata, 8'h11);
    b_mbsel = 1'b0; #1;
    chk(b_rdata === 8'h3C, "R6 fifo word shown", b_rdata, 8'h3C);

    // R3 refused store
    apply_a(1'b0, 1'b1, 1'b1, 1'b1, 8'h22);
    chkb("R3 a_mb1_n stays low", a_mb1_n, 1'b0);
    b_mbsel = 1'b1; #1;
    chk(b_rdata === 8'h11, "R3 word unchanged", b_rdata, 8'h11);

    // R6 fifo read does not clear
    apply_b(1'b0, 1'b1, 1'b0, 1'b0, '0);
    chkb("R6 b_mb1_n kept", b_mb1_n, 1'b0);
    wait_a(3);
    chkb("R6 a_mb1_n kept", a_mb1_n, 1'b0);

    // R5 clearing read and return timing
    apply_b(1'b0, 1'b1, 1'b0, 1'b1, '0);
    chkb("R5 b_mb1_n high at read edge", b_mb1_n, 1'b1);
    wait_a(1);
    chkb("R5 a_mb1_n after first edge", a_mb1_n, 1'b0);
    wait_a(1);
    chkb("R5 a_mb1_n after second edge", a_mb1_n, 1'b1);

    // R7 sweep of port A controls against mailbox 1
    last = 8'h11;
    for (int c = 0; c < 16; c++) begin
      logic [W-1:0] d;
      logic hit;
      d = 8'h40 + W'(c);
      hit = (c == 14);
      apply_a(c[0], c[1], c[2], c[3], d);
      chkb($sformatf("R7 a_mb1_n combo %0d", c), a_mb1_n, !hit);
      wait_b(3);
      b_mbsel = 1'b1; #1;
      chk(b_rdata === (hit ? d : last), $sformatf("R7 word combo %0d", c), b_rdata, hit ? d : last);
      chkb($sformatf("R7 b_mb1_n combo %0d", c), b_mb1_n, !hit);
      if (hit) begin
        last = d;
        apply_b(1'b0, 1'b1, 1'b0, 1'b1, '0);
        wait_a(3);
        chkb("R5 a_mb1_n after clear in sweep", a_mb1_n, 1'b1);
      end
    end

    // R7 sweep of port B read controls with mail pending
    apply_a(1'b0, 1'b1, 1'b1, 1'b1, 8'h77);
    wait_b(3);
    cleared = 1'b0;
    for (int c = 0; c < 16; c++) begin
      if (c[2] == 1'b0) begin
        apply_b(c[0], c[1], 1'b0, c[3], '0);
        if (c == 10) cleared = 1'b1;
        chkb($sformatf("R7 b_mb1_n read combo %0d", c), b_mb1_n, cleared);
      end
    end
    wait_a(3);
    chkb("R7 a_mb1_n after read sweep", a_mb1_n, 1'b1);

    // R8 mailbox 2
    apply_b(1'b0, 1'b1, 1'b1, 1'b1, 8'h5A);
    chkb("R8 b_mb2_n low after store", b_mb2_n, 1'b0);
    wait_a(1);
    chkb("R8 a_mb2_n after first edge", a_mb2_n, 1'b1);
    wait_a(1);
    chkb("R8 a_mb2_n after second edge", a_mb2_n, 1'b0);
    a_mbsel = 1'b1; #1;
    chk(a_rdata === 8'h5A, "R8 mailbox 2 word", a_rdata, 8'h5A);
    a_mbsel = 1'b0; #1;
    chk(a_rdata === 8'hA5, "R8 fifo word at A", a_rdata, 8'hA5);
    apply_b(1'b0, 1'b1, 1'b1, 1'b1, 8'h66);
    a_mbsel = 1'b1; #1;
    chk(a_rdata === 8'h5A, "R8 refused store", a_rdata, 8'h5A);
    apply_a(1'b0, 1'b1, 1'b0, 1'b0, '0);
    chkb("R8 fifo read keeps flag", a_mb2_n, 1'b0);
    apply_a(1'b0, 1'b1, 1'b0, 1'b1, '0);
    chkb("R8 a_mb2_n high at read edge", a_mb2_n, 1'b1);
    wait_b(1);
    chkb("R8 b_mb2_n after first edge", b_mb2_n, 1'b0);
    wait_b(1);
    chkb("R8 b_mb2_n after second edge", b_mb2_n, 1'b1);
    apply_b(1'b0, 1'b1, 1'b1, 1'b1, 8'h99);
    wait_a(3);
    a_mbsel = 1'b1; #1;
    chk(a_rdata === 8'h99, "R9 store after clear", a_rdata, 8'h99);

    finish_run();
  end
endmodule